// File: doc/BRIEF.md
# BCD calendar clock register bank

This block is the timekeeping core of a real-time clock. It holds seconds, minutes, hours, day of month, weekday, month and a two-digit year as packed BCD bytes. A sub-second tick input drives an internal prescaler, and the calendar advances by one second after every `TICKS_PER_SEC` ticks. Rollover covers minutes and hours, month lengths and leap years, and the weekday advances with each new day.

Software reaches the core through a byte-wide port. The port has an address, a write enable, write data and combinational read data. A control byte can freeze counting so that a consistent time can be loaded. The same byte selects whether the hour byte is counted in 24-hour or 12-hour form. A sticky flag in the top bit of the seconds byte tells software that the time cannot be trusted: it is set by reset and stays set until software clears it.

Top module: `rtc_bcd_core`

## Requirements
- R1: After reset the control byte reads 0x00 and seconds reads 0x80 (flag set, 00 s). Minutes, hours, weekday and year read 0x00, and day and month read 0x01.
- R2: The control byte is at address 0x00: bit 5 freezes counting and bit 1 selects 12-hour form. Its other bits read 0. The time bytes are at 0x04..0x0A in the order seconds, minutes, hours, day, weekday, month, year. Field widths are seconds 6:0, minutes 6:0, hours 5:0, day 5:0, weekday 2:0, month 4:0 and year 7:0. Bits outside a field are stored as 0 and read as 0, and a read shows the current state in the same cycle.
- R3: With counting enabled the seconds advance on every `TICKS_PER_SEC`-th tick pulse. Any write to the control byte clears the prescaler, so the first advance comes `TICKS_PER_SEC` ticks after that write. A tick that arrives in the same cycle as a control write never advances the time.
- R4: While bit 5 of the control byte is set, tick pulses change no time byte, but time bytes still take writes.
- R5: Seconds and minutes wrap from 59 to 00 and carry. In 24-hour form the hour wraps from 23 to 00 and the day advances.
- R6: In 12-hour form, bits 4:0 of the hour byte hold BCD 01..12 and bit 5 marks PM. The hour steps 11 AM to 12 PM (0x11 to 0x32), 12 PM to 1 PM (0x32 to 0x21), and 11 PM to 12 AM (0x31 to 0x12). Only the last of these advances the day.
- R7: The weekday is binary 0..6, increments on every day advance and wraps from 6 to 0.
- R8: The day wraps to 01 after day 31, 30 (months 04, 06, 09, 11) or 28. In February the day wraps after 29 when the year is a multiple of 4.
- R9: The month wraps from 12 to 01 and advances the year, and the year wraps from 99 to 00.
- R10: The validity flag (seconds bit 7) only changes on a write to address 0x04, where it takes bit 7 of the written byte. Counting never changes it.
- R11: Addresses 0x01..0x03 and 0x0B..0xFF read 0x00, and writes to them change no register.
- R12: A write to a time byte in the same cycle as a one-second advance stores the written value in that byte. All other bytes take their advanced values.
- R13: Changing the hour form does not convert the stored hour byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Sub-second tick pulse, one clock wide |
| addr_i | input | ADDR_W (8) | Register address |
| wr_en_i | input | 1 | Write strobe for the addressed register |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data for the addressed register, combinational |

## Verification
Two events can fall in the same cycle: a software write and the one-second advance. When the write goes to a time byte, the bench raises the write strobe together with the tick that completes a second, at seconds 59. It expects the written seconds value with the minutes advanced. When the write goes to the control byte, the bench lines it up with the final tick of a second. It expects no advance at all, and the next advance only after a full set of ticks. Constrained-random loads biased toward 59, 23, 11, month ends, 12 and 99 are compared against a binary reference model in the bench.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef struct packed {
    logic [6:0] sec;
    logic [6:0] min;
    logic [5:0] hour;
    logic [5:0] day;
    logic [2:0] wday;
    logic [4:0] mon;
    logic [7:0] year;
  } rtc_time_t;

  // Register map (decoded by software)
  localparam int CTRL_ADDR      = 0;
  localparam int TIME_BASE_ADDR = 4;
  localparam int NUM_TIME_REGS  = 7;

  // Field index within the time register window
  localparam int IDX_SEC  = 0;
  localparam int IDX_MIN  = 1;
  localparam int IDX_HOUR = 2;
  localparam int IDX_DAY  = 3;
  localparam int IDX_WDAY = 4;
  localparam int IDX_MON  = 5;
  localparam int IDX_YEAR = 6;

  // Bit positions
  localparam int STOP_BIT = 5;
  localparam int FMT_BIT  = 1;
  localparam int OSF_BIT  = 7;
  localparam int PM_BIT   = 5;

  // Increment a two-digit packed BCD value (no wrap of the tens digit)
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] >= 4'd9) begin
      r[3:0] = 4'd0;
      r[7:4] = v[7:4] + 4'd1;
    end else begin
      r[3:0] = v[3:0] + 4'd1;
      r[7:4] = v[7:4];
    end
    return r;
  endfunction

  // Year (BCD) is a multiple of four
  function automatic logic year_is_leap(input logic [7:0] y);
    logic [7:0] b;
    b = ({4'd0, y[7:4]} * 8'd10) + {4'd0, y[3:0]};
    return (b & 8'd3) == 8'd0;
  endfunction

  // Last day (BCD) of a BCD month
  function automatic logic [5:0] month_last_day(input logic [4:0] m, input logic [7:0] y);
    logic [5:0] r;
    case (m)
      5'h02:                      r = year_is_leap(y) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: r = 6'h30;
      default:                    r = 6'h31;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rtc_tick_div.sv
module rtc_tick_div #(
  parameter int TICKS_PER_SEC = 4,
  localparam int CNT_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             clear_i,
  output logic             sec_pulse_o,
  output logic [CNT_W-1:0] count_o
);

  generate
    if (TICKS_PER_SEC > 1) begin : g_div
      localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_SEC - 1);
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk) begin
        if (rst || clear_i) begin
          cnt_q <= '0;
        end else if (tick_i && run_i) begin
          cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CNT_W'(1);
        end
      end

      assign sec_pulse_o = tick_i && run_i && !clear_i && (cnt_q == LAST);
      assign count_o     = cnt_q;
    end else begin : g_direct
      assign sec_pulse_o = tick_i && run_i && !clear_i;
      assign count_o     = '0;
    end
  endgenerate

endmodule

// File: rtl/rtc_cal_step.sv
module rtc_cal_step
  import rtc_pkg::*;
(
  input  rtc_time_t cur_i,
  input  logic      mode12_i,
  output rtc_time_t nxt_o,
  output logic      day_roll_o
);

  logic [7:0] inc_sec, inc_min, inc_h24, inc_h12, inc_day, inc_mon, inc_year;
  logic [5:0] last_day;
  logic       min_c, hour_c, day_c, mon_c, year_c;
  logic       pm;

  assign inc_sec  = bcd_inc({1'b0, cur_i.sec});
  assign inc_min  = bcd_inc({1'b0, cur_i.min});
  assign inc_h24  = bcd_inc({2'b0, cur_i.hour});
  assign inc_h12  = bcd_inc({3'b0, cur_i.hour[4:0]});
  assign inc_day  = bcd_inc({2'b0, cur_i.day});
  assign inc_mon  = bcd_inc({3'b0, cur_i.mon});
  assign inc_year = bcd_inc(cur_i.year);
  assign last_day = month_last_day(cur_i.mon, cur_i.year);
  assign pm       = cur_i.hour[PM_BIT];

  always_comb begin
    nxt_o  = cur_i;
    min_c  = 1'b0;
    hour_c = 1'b0;
    day_c  = 1'b0;
    mon_c  = 1'b0;
    year_c = 1'b0;

    // seconds
    if (cur_i.sec >= 7'h59) begin
      nxt_o.sec = 7'h00;
      min_c     = 1'b1;
    end else begin
      nxt_o.sec = 7'(inc_sec);
    end

    // minutes
    if (min_c) begin
      if (cur_i.min >= 7'h59) begin
        nxt_o.min = 7'h00;
        hour_c    = 1'b1;
      end else begin
        nxt_o.min = 7'(inc_min);
      end
    end

    // hours
    if (hour_c) begin
      if (mode12_i) begin
        if (cur_i.hour[4:0] == 5'h11) begin
          nxt_o.hour = {~pm, 5'h12};
          day_c      = pm;
        end else if (cur_i.hour[4:0] >= 5'h12) begin
          nxt_o.hour = {pm, 5'h01};
        end else begin
          nxt_o.hour = {pm, 5'(inc_h12)};
        end
      end else begin
        if (cur_i.hour >= 6'h23) begin
          nxt_o.hour = 6'h00;
          day_c      = 1'b1;
        end else begin
          nxt_o.hour = 6'(inc_h24);
        end
      end
    end

    // day and weekday
    if (day_c) begin
      nxt_o.wday = (cur_i.wday >= 3'd6) ? 3'd0 : cur_i.wday + 3'd1;
      if (cur_i.day >= last_day) begin
        nxt_o.day = 6'h01;
        mon_c     = 1'b1;
      end else begin
        nxt_o.day = 6'(inc_day);
      end
    end

    // month
    if (mon_c) begin
      if (cur_i.mon >= 5'h12) begin
        nxt_o.mon = 5'h01;
        year_c    = 1'b1;
      end else begin
        nxt_o.mon = 5'(inc_mon);
      end
    end

    // year
    if (year_c) begin
      nxt_o.year = (cur_i.year >= 8'h99) ? 8'h00 : inc_year;
    end
  end

  assign day_roll_o = day_c;

endmodule

// File: rtl/rtc_reg_if.sv
module rtc_reg_if
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                     wr_en_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic                     stop_i,
  input  logic                     mode12_i,
  input  logic                     osf_i,
  input  rtc_time_t                tm_i,
  output logic                     ctrl_we_o,
  output logic [NUM_TIME_REGS-1:0] fld_we_o,
  output logic [7:0]               rd_data_o
);

  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(TIME_BASE_ADDR);
  localparam logic [ADDR_W-1:0] NUM_A  = ADDR_W'(NUM_TIME_REGS);

  logic [7:0]        rd_vals [NUM_TIME_REGS];
  logic [7:0]        ctrl_byte;
  logic [ADDR_W-1:0] offs;
  logic              in_window;

  assign ctrl_we_o = wr_en_i && (addr_i == CTRL_A);
  assign offs      = addr_i - BASE_A;
  assign in_window = (addr_i >= BASE_A) && (offs < NUM_A);

  genvar gi;
  generate
    for (gi = 0; gi < NUM_TIME_REGS; gi++) begin : g_we
      assign fld_we_o[gi] = wr_en_i && (addr_i == ADDR_W'(TIME_BASE_ADDR + gi));
    end
  endgenerate

  always_comb begin
    ctrl_byte           = 8'h00;
    ctrl_byte[STOP_BIT] = stop_i;
    ctrl_byte[FMT_BIT]  = mode12_i;
  end

  assign rd_vals[IDX_SEC]  = {osf_i, tm_i.sec};
  assign rd_vals[IDX_MIN]  = {1'b0, tm_i.min};
  assign rd_vals[IDX_HOUR] = {2'b0, tm_i.hour};
  assign rd_vals[IDX_DAY]  = {2'b0, tm_i.day};
  assign rd_vals[IDX_WDAY] = {5'b0, tm_i.wday};
  assign rd_vals[IDX_MON]  = {3'b0, tm_i.mon};
  assign rd_vals[IDX_YEAR] = tm_i.year;

  always_comb begin
    rd_data_o = 8'h00;
    if (addr_i == CTRL_A) begin
      rd_data_o = ctrl_byte;
    end else if (in_window) begin
      rd_data_o = rd_vals[offs[2:0]];
    end
  end

endmodule

// File: rtl/rtc_bcd_core.sv
module rtc_bcd_core
  import rtc_pkg::*;
#(
  parameter int ADDR_W        = 8,
  parameter int TICKS_PER_SEC = 4,
  localparam int CNT_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [7:0]        wr_data_i,
  output logic [7:0]        rd_data_o
);

  logic                     stop_q, mode12_q, osf_q;
  rtc_time_t                tm_q, tm_d, tm_nxt;
  logic                     ctrl_we, sec_pulse, day_roll;
  logic [NUM_TIME_REGS-1:0] fld_we;
  logic [CNT_W-1:0]         presc_cnt;

  rtc_reg_if #(.ADDR_W(ADDR_W)) u_regs (
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .stop_i    (stop_q),
    .mode12_i  (mode12_q),
    .osf_i     (osf_q),
    .tm_i      (tm_q),
    .ctrl_we_o (ctrl_we),
    .fld_we_o  (fld_we),
    .rd_data_o (rd_data_o)
  );

  rtc_tick_div #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_div (
    .clk         (clk),
    .rst         (rst),
    .tick_i      (tick_i),
    .run_i       (!stop_q),
    .clear_i     (ctrl_we),
    .sec_pulse_o (sec_pulse),
    .count_o     (presc_cnt)
  );

  rtc_cal_step u_step (
    .cur_i      (tm_q),
    .mode12_i   (mode12_q),
    .nxt_o      (tm_nxt),
    .day_roll_o (day_roll)
  );

  // Merge: advanced values, then per-field software writes take priority
  always_comb begin
    tm_d = sec_pulse ? tm_nxt : tm_q;
    if (fld_we[IDX_SEC])  tm_d.sec  = wr_data_i[6:0];
    if (fld_we[IDX_MIN])  tm_d.min  = wr_data_i[6:0];
    if (fld_we[IDX_HOUR]) tm_d.hour = wr_data_i[5:0];
    if (fld_we[IDX_DAY])  tm_d.day  = wr_data_i[5:0];
    if (fld_we[IDX_WDAY]) tm_d.wday = wr_data_i[2:0];
    if (fld_we[IDX_MON])  tm_d.mon  = wr_data_i[4:0];
    if (fld_we[IDX_YEAR]) tm_d.year = wr_data_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stop_q   <= 1'b0;
      mode12_q <= 1'b0;
      osf_q    <= 1'b1;
      tm_q     <= '{sec: 7'h00, min: 7'h00, hour: 6'h00, day: 6'h01,
                    wday: 3'd0, mon: 5'h01, year: 8'h00};
    end else begin
      if (ctrl_we) begin
        stop_q   <= wr_data_i[STOP_BIT];
        mode12_q <= wr_data_i[FMT_BIT];
      end
      if (fld_we[IDX_SEC]) begin
        osf_q <= wr_data_i[OSF_BIT];
      end
      tm_q <= tm_d;
    end
  end

endmodule

// File: rtl/rtc_bcd_core_chk.sv
module rtc_bcd_core_chk
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic              stop_q,
  input logic              mode12_q,
  input logic              osf_q,
  input rtc_time_t         tm_q,
  input logic              sec_pulse,
  input logic              day_roll,
  input logic [CNT_W-1:0]  presc_cnt
);

  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] SEC_A  = ADDR_W'(TIME_BASE_ADDR);

  // R1: reset leaves the flag set and a valid calendar date
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (osf_q && tm_q.day == 6'h01 && tm_q.mon == 5'h01 && !stop_q));

  // R3: the time never moves without a one-second pulse or a write
  a_r3_no_spurious: assert property (@(posedge clk) disable iff (rst)
    (!sec_pulse && !wr_en) |=> $stable(tm_q));

  // R3: a control write clears the prescaler
  a_r3_presc_clear: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == CTRL_A) |=> (presc_cnt == '0));

  // R4: frozen counting keeps every time field
  a_r4_stop_freeze: assert property (@(posedge clk) disable iff (rst)
    (stop_q && !wr_en) |=> $stable(tm_q));

  // R5: seconds wrap at 59
  a_r5_sec_wrap: assert property (@(posedge clk) disable iff (rst)
    (sec_pulse && !wr_en && tm_q.sec == 7'h59) |=> (tm_q.sec == 7'h00));

  // R7: weekday wraps from 6 to 0 on a day advance
  a_r7_wday_wrap: assert property (@(posedge clk) disable iff (rst)
    (sec_pulse && !wr_en && day_roll && tm_q.wday == 3'd6) |=> (tm_q.wday == 3'd0));

  // R10: the flag is sticky unless the seconds byte is written
  a_r10_osf_sticky: assert property (@(posedge clk) disable iff (rst)
    (osf_q && !(wr_en && addr == SEC_A)) |=> osf_q);

  // R11: control bits change only through address 0x00
  a_r11_ctrl_only_addr0: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == CTRL_A) |=> $stable({stop_q, mode12_q}));

endmodule

bind rtc_bcd_core rtc_bcd_core_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en_i),
  .addr      (addr_i),
  .stop_q    (stop_q),
  .mode12_q  (mode12_q),
  .osf_q     (osf_q),
  .tm_q      (tm_q),
  .sec_pulse (sec_pulse),
  .day_roll  (day_roll),
  .presc_cnt (presc_cnt)
);

// File: tb/rtc_bcd_core_bench.sv
module rtc_bcd_core_bench;

  localparam int CLK_PERIOD = 10;
  localparam int TPS        = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic [7:0] addr = 8'h00;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_bcd_core #(.ADDR_W(8), .TICKS_PER_SEC(TPS)) u_rtc_bcd_core (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (tick),
    .addr_i    (addr),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .rd_data_o (rd_data)
  );

  typedef struct {
    int s; int m; int h; int d; int w; int mo; int y;
  } tm_t;

  function automatic logic [7:0] bcd(input int n);
    return 8'((n / 10) * 16 + (n % 10));
  endfunction

  function automatic int dim(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] henc(input int h, input bit m12);
    int hh;
    if (!m12) return bcd(h);
    hh = h % 12;
    if (hh == 0) hh = 12;
    return bcd(hh) | ((h >= 12) ? 8'h20 : 8'h00);
  endfunction

  function automatic tm_t step(input tm_t t);
    tm_t r = t;
    r.s++;
    if (r.s == 60) begin
      r.s = 0; r.m++;
      if (r.m == 60) begin
        r.m = 0; r.h++;
        if (r.h == 24) begin
          r.h = 0; r.d++; r.w = (r.w + 1) % 7;
          if (r.d > dim(r.mo, r.y)) begin
            r.d = 1; r.mo++;
            if (r.mo == 13) begin r.mo = 1; r.y = (r.y + 1) % 100; end
          end
        end
      end
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic one_second();
    for (int i = 0; i < TPS; i++) pulse_tick();
  endtask

  task automatic load(input tm_t t, input bit m12);
    logic [7:0] fmt;
    fmt = m12 ? 8'h02 : 8'h00;
    wr(8'h00, 8'h20 | fmt);
    wr(8'h04, bcd(t.s));
    wr(8'h05, bcd(t.m));
    wr(8'h06, henc(t.h, m12));
    wr(8'h07, bcd(t.d));
    wr(8'h08, 8'(t.w));
    wr(8'h09, bcd(t.mo));
    wr(8'h0A, bcd(t.y));
    wr(8'h00, fmt);
  endtask

  task automatic compare(input string tag, input tm_t t, input bit m12);
    logic [7:0] v;
    rd(8'h04, v); chk({tag, " sec"},  v, bcd(t.s));
    rd(8'h05, v); chk({tag, " min"},  v, bcd(t.m));
    rd(8'h06, v); chk({tag, " hour"}, v, henc(t.h, m12));
    rd(8'h07, v); chk({tag, " day"},  v, bcd(t.d));
    rd(8'h08, v); chk({tag, " wday"}, v, 8'(t.w));
    rd(8'h09, v); chk({tag, " mon"},  v, bcd(t.mo));
    rd(8'h0A, v); chk({tag, " year"}, v, bcd(t.y));
  endtask

  function automatic int pick(input int lim, input int edge_v);
    return ($urandom % 3 == 0) ? edge_v : int'($urandom % lim);
  endfunction

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] v;
    tm_t t, e;
    int unsigned seed;
    seed = $urandom(32'd20240607);

    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    rd(8'h00, v); chk("R1 ctrl", v, 8'h00);
    rd(8'h04, v); chk("R1 sec with flag", v, 8'h80);
    rd(8'h05, v); chk("R1 min", v, 8'h00);
    rd(8'h06, v); chk("R1 hour", v, 8'h00);
    rd(8'h07, v); chk("R1 day", v, 8'h01);
    rd(8'h08, v); chk("R1 wday", v, 8'h00);
    rd(8'h09, v); chk("R1 mon", v, 8'h01);
    rd(8'h0A, v); chk("R1 year", v, 8'h00);

    // R2: control bits and masking
    wr(8'h00, 8'hFF);
    rd(8'h00, v); chk("R2 ctrl mask", v, 8'h22);
    wr(8'h05, 8'hFF);
    rd(8'h05, v); chk("R2 min field mask", v, 8'h7F);
    wr(8'h08, 8'hFD);
    rd(8'h08, v); chk("R2 wday field mask", v, 8'h05);

    // R13: format change keeps stored hour
    wr(8'h00, 8'h20);
    wr(8'h06, 8'h15);
    wr(8'h00, 8'h22);
    rd(8'h06, v); chk("R13 hour not converted", v, 8'h15);

    // R4: frozen counting, writes still accepted; R3 restart timing
    t = '{s: 58, m: 59, h: 23, d: 28, w: 3, mo: 2, y: 24};
    load(t, 1'b0);
    wr(8'h00, 8'h20);
    for (int i = 0; i < 2 * TPS; i++) pulse_tick();
    rd(8'h04, v); chk("R4 frozen sec", v, 8'h58);
    wr(8'h05, 8'h59);
    rd(8'h05, v); chk("R4 write while frozen", v, 8'h59);
    wr(8'h00, 8'h00);
    for (int i = 0; i < TPS - 1; i++) pulse_tick();
    rd(8'h04, v); chk("R3 no advance before full second", v, 8'h58);
    pulse_tick();
    rd(8'h04, v); chk("R3 advance after full second", v, 8'h59);
    one_second();
    e = '{s: 0, m: 0, h: 0, d: 29, w: 4, mo: 2, y: 24};
    compare("R5/R7/R8 leap Feb 28 to 29", e, 1'b0);

    // R8: non-leap February and 30-day month
    load('{s: 59, m: 59, h: 23, d: 28, w: 6, mo: 2, y: 23}, 1'b0);
    one_second();
    compare("R7/R8 non-leap Feb to Mar", '{s: 0, m: 0, h: 0, d: 1, w: 0, mo: 3, y: 23}, 1'b0);
    load('{s: 59, m: 59, h: 23, d: 30, w: 1, mo: 4, y: 23}, 1'b0);
    one_second();
    compare("R8 Apr 30 to May 1", '{s: 0, m: 0, h: 0, d: 1, w: 2, mo: 5, y: 23}, 1'b0);

    // R9: year wrap
    load('{s: 59, m: 59, h: 23, d: 31, w: 5, mo: 12, y: 99}, 1'b0);
    one_second();
    compare("R9 year 99 to 00", '{s: 0, m: 0, h: 0, d: 1, w: 6, mo: 1, y: 0}, 1'b0);

    // R6: 12-hour sequence
    load('{s: 59, m: 59, h: 11, d: 10, w: 2, mo: 7, y: 30}, 1'b1);
    one_second();
    rd(8'h06, v); chk("R6 11AM to 12PM", v, 8'h32);
    rd(8'h07, v); chk("R6 no day change at noon", v, 8'h10);
    load('{s: 59, m: 59, h: 12, d: 10, w: 2, mo: 7, y: 30}, 1'b1);
    one_second();
    rd(8'h06, v); chk("R6 12PM to 1PM", v, 8'h21);
    load('{s: 59, m: 59, h: 23, d: 10, w: 2, mo: 7, y: 30}, 1'b1);
    one_second();
    rd(8'h06, v); chk("R6 11PM to 12AM", v, 8'h12);
    rd(8'h07, v); chk("R6 day advances at midnight", v, 8'h11);
    rd(8'h08, v); chk("R6 weekday advances at midnight", v, 8'h03);

    // R12: time write coincides with an advance
    load('{s: 59, m: 10, h: 5, d: 3, w: 1, mo: 6, y: 40}, 1'b0);
    for (int i = 0; i < TPS - 1; i++) pulse_tick();
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; addr = 8'h04; wr_data = 8'h30;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    rd(8'h04, v); chk("R12 written seconds win", v, 8'h30);
    rd(8'h05, v); chk("R12 minutes still advance", v, 8'h11);

    // R3: control write coincides with the final tick
    load('{s: 20, m: 0, h: 1, d: 1, w: 0, mo: 1, y: 1}, 1'b0);
    for (int i = 0; i < TPS - 1; i++) pulse_tick();
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; addr = 8'h00; wr_data = 8'h00;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    rd(8'h04, v); chk("R3 ctrl write suppresses advance", v, 8'h20);
    for (int i = 0; i < TPS - 1; i++) pulse_tick();
    rd(8'h04, v); chk("R3 prescaler restarted", v, 8'h20);
    pulse_tick();
    rd(8'h04, v); chk("R3 advance after restart", v, 8'h21);

    // R10: flag behaviour
    wr(8'h04, 8'h85);
    rd(8'h04, v); chk("R10 flag set by write", v, 8'h85);
    one_second();
    rd(8'h04, v); chk("R10 flag kept while counting", v, 8'h86);
    wr(8'h05, 8'h00);
    rd(8'h04, v); chk("R10 flag kept on other write", v, 8'h86);
    wr(8'h04, 8'h07);
    rd(8'h04, v); chk("R10 flag cleared by write", v, 8'h07);

    // R11: unmapped addresses
    wr(8'h00, 8'h20);
    wr(8'h04, 8'h12);
    wr(8'h01, 8'hFF); wr(8'h02, 8'hFF); wr(8'h03, 8'hFF);
    wr(8'h0B, 8'hFF); wr(8'hFF, 8'hFF);
    rd(8'h02, v); chk("R11 read 0x02", v, 8'h00);
    rd(8'h0B, v); chk("R11 read 0x0B", v, 8'h00);
    rd(8'hFF, v); chk("R11 read 0xFF", v, 8'h00);
    rd(8'h00, v); chk("R11 ctrl untouched", v, 8'h20);
    rd(8'h04, v); chk("R11 sec untouched", v, 8'h12);

    // Constrained random loads checked against the model (R5 R6 R7 R8 R9)
    for (int it = 0; it < 40; it++) begin
      bit m12;
      int n;
      m12  = 1'($urandom % 2);
      t.s  = pick(60, 59);
      t.m  = pick(60, 59);
      t.h  = pick(24, (($urandom % 2) == 0) ? 23 : 11);
      t.mo = ($urandom % 3 == 0) ? ((($urandom % 2) == 0) ? 12 : 2) : 1 + int'($urandom % 12);
      t.y  = pick(100, 99);
      t.d  = ($urandom % 2 == 0) ? dim(t.mo, t.y) : 1 + int'($urandom % dim(t.mo, t.y));
      t.w  = int'($urandom % 7);
      n    = 1 + int'($urandom % 3);
      load(t, m12);
      for (int k = 0; k < n; k++) begin
        one_second();
        t = step(t);
      end
      compare("R5/R6/R7/R8/R9 random", t, m12);
    end

    // R1: reset again restores the flag
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    rd(8'h04, v); chk("R1 flag after second reset", v, 8'h80);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule